// File: doc/BRIEF.md
# Captured Sample Byte Streamer

This block turns a run of captured 32-bit samples held in a sample memory into a stream of bytes for a byte-wide serial transmitter. A start pulse gives it a read count, in units of four samples, and a first memory address. For each sample it reads one word from the memory. It then offers that word's bytes to the transmitter over a valid/ready handshake. When the run is over it pulses done. There is no header, trailer or separator anywhere in the stream.

The 32 probe channels fall into four groups of eight. A four-bit disable mask drops whole groups from the stream, which shortens each sample's contribution to between zero and four bytes. Pause and resume inputs are intended to be pulsed when XOFF and XON bytes are received. They freeze the stream at a byte boundary and let it pick up again where it stopped. When idle, the block can also answer an identification request with a fixed four-byte reply.

Top module: `capture_byte_streamer`

## Requirements
- R1: Within a sample, bytes leave in group order 0, 1, 2, 3, and group g carries sample bits [8g+7:8g], so the first byte holds the lowest channels.
- R2: Disable-mask bit g (`groupOff[g]`=1) removes group g's byte from the stream completely, with nothing sent in its place.
- R3: With all four mask bits set, every sample is still read and stepped through, no byte is offered, and done still pulses.
- R4: A start reads exactly 4×`readCount` samples from consecutive addresses that begin at `startAddr` and wrap at the top of the address range. A `readCount` of 0 performs no reads, sends no bytes and pulses done.
- R5: Once `txValid` is high, it and `txData` stay unchanged until a cycle in which `txReady` is high.
- R6: After a `pauseReq` pulse, no new sample byte is offered. A byte already offered still completes its handshake, and the run does not finish while paused.
- R7: After a `resumeReq` pulse, the stream continues with the pending byte of the pending sample, with nothing lost or repeated.
- R8: An `idReq` pulse while idle produces the bytes 0x53, 0x4C, 0x41 ('S','L','A') and then 0x30+PROTO_VER. This reply is sent even while paused.
- R9: `done` is high for exactly one cycle, after the final byte of the final sample is accepted (or the final sample is skipped), and `busy` is low from the next cycle.
- R10: `startReq` and `idReq` have no effect while `busy` is high.
- R11: After reset, `txValid`, `done`, `busy` and `memRdEn` are low and the stream is not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Pulse: begin a run (idle only) |
| readCount | input | CNT_W | Run length in units of four samples |
| startAddr | input | ADDR_W | First memory address of the run |
| groupOff | input | 4 | Per-group disable mask, bit g for channels 8g..8g+7 |
| idReq | input | 1 | Pulse: send the identification reply (idle only) |
| pauseReq | input | 1 | Pulse: stop offering sample bytes |
| resumeReq | input | 1 | Pulse: continue the stream |
| memRdEn | output | 1 | Memory read strobe, data returns one cycle later |
| memAddr | output | ADDR_W | Memory read address |
| memData | input | 32 | Memory read data |
| txData | output | 8 | Byte offered to the transmitter |
| txValid | output | 1 | txData is valid |
| txReady | input | 1 | Transmitter accepts the byte this cycle |
| busy | output | 1 | A run or reply is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench builds the block with a 6-bit address, a 4-bit read count and protocol version 0. With the narrow address, a run that starts at address 60 wraps to the bottom of memory within a few samples. With the narrow read count, the largest run (60 samples) completes quickly. Version 0 makes the last identification byte differ from the default build. The transmitter's ready input either stays high or is high only one cycle in three, so the byte hold is exercised under back-pressure, and mask patterns from none disabled to all disabled are covered.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  localparam int GROUPS = 4;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = $clog2(GROUPS);
  localparam int WORD_W = GROUPS * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_SEND,
    ST_ID,
    ST_DONE
  } streamState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadAddr;
    logic             incAddr;
    logic             loadSample;
    logic             launch;
    logic             useId;
    logic [SEL_W-1:0] byteSel;
  } dpStrobe_t;

  function automatic logic [BYTE_W-1:0] idChar(input logic [SEL_W-1:0] idx, input int ver);
    case (idx)
      2'd0:    idChar = 8'h53;
      2'd1:    idChar = 8'h4C;
      2'd2:    idChar = 8'h41;
      default: idChar = 8'h30 + 8'(ver);
    endcase
  endfunction

endpackage

// File: rtl/cbs_stream_ctrl.sv
module cbs_stream_ctrl
  import cbs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             idReq,
  input  logic [CNT_W-1:0] readCount,
  input  logic [GROUPS-1:0] groupOff,
  input  logic             pauseReq,
  input  logic             resumeReq,
  input  logic             txReady,
  output logic             txValid,
  output logic             memRdEn,
  output logic             busy,
  output logic             done,
  output dpStrobe_t        strobe
);

  localparam int UNIT_SHIFT = 2;
  localparam int LEFT_W     = CNT_W + UNIT_SHIFT;

  streamState_t     state, stateNext;
  logic [SEL_W-1:0] byteIdx;
  logic [LEFT_W-1:0] samplesLeft;
  logic             paused;
  logic             txValidQ;
  logic             advance;
  logic             groupOn;
  logic             lastByte;
  logic             lastSample;

  assign groupOn    = !groupOff[byteIdx];
  assign lastByte   = (byteIdx == SEL_W'(GROUPS - 1));
  assign lastSample = (samplesLeft == LEFT_W'(1));

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    strobe.byteSel = byteIdx;
    advance        = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.loadAddr = 1'b1;
          stateNext = (readCount == '0) ? ST_DONE : ST_FETCH;
        end else if (idReq) begin
          stateNext = ST_ID;
        end
      end
      ST_FETCH: stateNext = ST_WAIT;
      ST_WAIT: begin
        strobe.loadSample = 1'b1;
        stateNext = ST_SEND;
      end
      ST_SEND: begin
        if (txValidQ) begin
          advance = txReady;
        end else if (!paused) begin
          if (groupOn) strobe.launch = 1'b1;
          else         advance = 1'b1;
        end
        if (advance && lastByte) begin
          if (lastSample) begin
            stateNext = ST_DONE;
          end else begin
            strobe.incAddr = 1'b1;
            stateNext = ST_FETCH;
          end
        end
      end
      ST_ID: begin
        if (txValidQ) begin
          advance = txReady;
          if (txReady && lastByte) stateNext = ST_IDLE;
        end else begin
          strobe.launch = 1'b1;
          strobe.useId  = 1'b1;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      byteIdx     <= '0;
      samplesLeft <= '0;
      paused      <= 1'b0;
      txValidQ    <= 1'b0;
    end else begin
      state <= stateNext;

      if (strobe.loadAddr)  byteIdx <= '0;
      else if (advance)     byteIdx <= lastByte ? '0 : byteIdx + 1'b1;

      if (strobe.loadAddr)
        samplesLeft <= {readCount, {UNIT_SHIFT{1'b0}}};
      else if (state == ST_SEND && advance && lastByte)
        samplesLeft <= samplesLeft - 1'b1;

      if (pauseReq)       paused <= 1'b1;
      else if (resumeReq) paused <= 1'b0;

      if (strobe.launch)           txValidQ <= 1'b1;
      else if (txValidQ && txReady) txValidQ <= 1'b0;
    end
  end

  assign txValid = txValidQ;
  assign memRdEn = (state == ST_FETCH);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

  assert_valid_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txValidQ && !txReady) |=> txValidQ);

  assert_pause_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (paused && !txValidQ && state == ST_SEND) |=> !txValidQ);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_single_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  assert_idle_no_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !txValidQ);

endmodule

// File: rtl/cbs_stream_dpath.sv
module cbs_stream_dpath
  import cbs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PROTO_VER = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] txData
);

  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] sampleQ;
  logic [BYTE_W-1:0] txDataQ;
  logic [BYTE_W-1:0] lane [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : gLane
    assign lane[g] = sampleQ[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      sampleQ <= '0;
      txDataQ <= '0;
    end else begin
      if (strobe.loadAddr)     addrQ <= startAddr;
      else if (strobe.incAddr) addrQ <= addrQ + 1'b1;

      if (strobe.loadSample) sampleQ <= memData;

      if (strobe.launch)
        txDataQ <= strobe.useId ? idChar(strobe.byteSel, PROTO_VER) : lane[strobe.byteSel];
    end
  end

  assign memAddr = addrQ;
  assign txData  = txDataQ;

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incAddr |=> (memAddr == $past(memAddr) + 1'b1));

  assert_addr_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAddr |=> (memAddr == $past(startAddr)));

endmodule

// File: rtl/capture_byte_streamer.sv
module capture_byte_streamer
  import cbs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int CNT_W     = 8,
  parameter int PROTO_VER = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  readCount,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [3:0]        groupOff,
  input  logic              idReq,
  input  logic              pauseReq,
  input  logic              resumeReq,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memData,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              busy,
  output logic              done
);

  dpStrobe_t strobe;

  cbs_stream_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .idReq     (idReq),
    .readCount (readCount),
    .groupOff  (groupOff),
    .pauseReq  (pauseReq),
    .resumeReq (resumeReq),
    .txReady   (txReady),
    .txValid   (txValid),
    .memRdEn   (memRdEn),
    .busy      (busy),
    .done      (done),
    .strobe    (strobe)
  );

  cbs_stream_dpath #(.ADDR_W(ADDR_W), .PROTO_VER(PROTO_VER)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startAddr (startAddr),
    .memData   (memData),
    .memAddr   (memAddr),
    .txData    (txData)
  );

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> $stable(txData));

endmodule

// File: tb/capture_byte_streamer_test.sv
module capture_byte_streamer_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 6;
  localparam int CW  = 4;
  localparam int VER = 0;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [CW-1:0] readCount = '0;
  logic [AW-1:0] startAddr = '0;
  logic [3:0]    groupOff = '0;
  logic          idReq = 1'b0;
  logic          pauseReq = 1'b0;
  logic          resumeReq = 1'b0;
  logic          memRdEn;
  logic [AW-1:0] memAddr;
  logic [31:0]   memData = '0;
  logic [7:0]    txData;
  logic          txValid;
  logic          txReady = 1'b0;
  logic          busy;
  logic          done;

  capture_byte_streamer #(.ADDR_W(AW), .CNT_W(CW), .PROTO_VER(VER)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .readCount(readCount),
    .startAddr(startAddr), .groupOff(groupOff), .idReq(idReq),
    .pauseReq(pauseReq), .resumeReq(resumeReq), .memRdEn(memRdEn),
    .memAddr(memAddr), .memData(memData), .txData(txData), .txValid(txValid),
    .txReady(txReady), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  cyc = 0;
  bit  slowReady = 1'b0;
  always @(posedge clk) begin
    cyc     <= cyc + 1;
    txReady <= slowReady ? (cyc % 3 == 0) : 1'b1;
  end

  function automatic logic [31:0] sampleOf(input logic [AW-1:0] a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'hF0, b + 8'h40, ~b, b};
  endfunction

  always @(posedge clk) if (memRdEn) memData <= sampleOf(memAddr);

  logic [7:0] rxLog  [512];
  logic [7:0] expLog [512];
  int rxCount = 0, doneCount = 0, rdCount = 0, expCount = 0;
  int checks = 0, fails = 0;

  always @(negedge clk) begin
    if (rstN && txValid && txReady) begin
      rxLog[rxCount] = txData;
      rxCount = rxCount + 1;
    end
    if (rstN && done)    doneCount = doneCount + 1;
    if (rstN && memRdEn) rdCount = rdCount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    rxCount = 0; doneCount = 0; rdCount = 0;
  endtask

  task automatic buildExp(input int cnt, input int start, input logic [3:0] mask);
    expCount = 0;
    for (int s = 0; s < cnt * 4; s++) begin
      logic [31:0] w;
      w = sampleOf(AW'(start + s));
      for (int g = 0; g < 4; g++)
        if (!mask[g]) begin
          expLog[expCount] = w[g*8 +: 8];
          expCount++;
        end
    end
  endtask

  task automatic compareStream(input string req);
    int bad;
    bad = -1;
    check(rxCount == expCount, req, rxCount, expCount);
    for (int i = 0; i < expCount && i < rxCount; i++)
      if (bad < 0 && rxLog[i] !== expLog[i]) bad = i;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, int'(rxLog[bad]), int'(expLog[bad]));
  endtask

  task automatic pulseStart(input int cnt, input int start, input logic [3:0] mask);
    @(negedge clk);
    readCount = CW'(cnt); startAddr = AW'(start); groupOff = mask; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic pulseId();
    @(negedge clk); idReq = 1'b1; @(negedge clk); idReq = 1'b0;
  endtask

  task automatic pulsePause();
    @(negedge clk); pauseReq = 1'b1; @(negedge clk); pauseReq = 1'b0;
  endtask

  task automatic pulseResume();
    @(negedge clk); resumeReq = 1'b1; @(negedge clk); resumeReq = 1'b0;
  endtask

  task automatic waitDone(input int limit);
    for (int i = 0; i < limit && doneCount == 0; i++) @(posedge clk);
  endtask

  // cnt[14:11] start[10:5] mask[4:1] slow[0]
  localparam logic [14:0] VECS [6] = '{
    {4'd1,  6'd0,  4'b0000, 1'b0},
    {4'd2,  6'd5,  4'b0101, 1'b1},
    {4'd3,  6'd60, 4'b1000, 1'b0},
    {4'd1,  6'd10, 4'b1111, 1'b0},
    {4'd15, 6'd33, 4'b0110, 1'b1},
    {4'd0,  6'd7,  4'b0000, 1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!txValid && !done && !busy && !memRdEn, "R11", int'({txValid, done, busy, memRdEn}), 0);

    // table-driven runs: R1 R2 R3 R4 R9
    for (int v = 0; v < 6; v++) begin
      int cnt, start;
      logic [3:0] mask;
      cnt = int'(VECS[v][14:11]); start = int'(VECS[v][10:5]); mask = VECS[v][4:1];
      slowReady = VECS[v][0];
      clearLog();
      buildExp(cnt, start, mask);
      pulseStart(cnt, start, mask);
      waitDone(5000);
      repeat (5) @(posedge clk);
      compareStream(mask == 4'hF ? "R3" : "R1_R2");
      check(rdCount == cnt * 4, "R4", rdCount, cnt * 4);
      check(doneCount == 1, "R9", doneCount, 1);
      check(!busy, "R9", int'(busy), 0);
    end

    // pause mid-stream, then resume: R6 R7
    slowReady = 1'b0;
    clearLog();
    buildExp(2, 20, 4'b0000);
    pulseStart(2, 20, 4'b0000);
    for (int i = 0; i < 200 && rxCount < 3; i++) @(posedge clk);
    pulsePause();
    repeat (4) @(posedge clk);
    begin
      int snap;
      snap = rxCount;
      repeat (40) @(posedge clk);
      check(rxCount == snap, "R6", rxCount, snap);
      check(doneCount == 0 && busy, "R6", doneCount, 0);
    end
    pulseResume();
    waitDone(2000);
    repeat (5) @(posedge clk);
    compareStream("R7");

    // identification reply while paused: R8
    clearLog();
    pulsePause();
    pulseId();
    repeat (20) @(posedge clk);
    check(rxCount == 4, "R8", rxCount, 4);
    check(rxLog[0] == 8'h53 && rxLog[1] == 8'h4C && rxLog[2] == 8'h41,
          "R8", int'({rxLog[0], rxLog[1], rxLog[2]}), 32'h534C41);
    check(rxLog[3] == 8'h30 + 8'(VER), "R8", int'(rxLog[3]), 8'h30 + VER);
    pulseResume();

    // requests while busy are ignored: R10
    slowReady = 1'b1;
    clearLog();
    buildExp(1, 2, 4'b0000);
    pulseStart(1, 2, 4'b0000);
    repeat (3) @(posedge clk);
    pulseId();
    pulseStart(3, 40, 4'b0000);
    waitDone(2000);
    repeat (40) @(posedge clk);
    compareStream("R10");
    check(doneCount == 1 && rdCount == 4, "R10", rdCount, 4);

    // hold under back-pressure is covered by assertions (R5); final idle check
    check(!txValid && !busy, "R5", int'({txValid, busy}), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule